// File: doc/BRIEF.md
# Cascaded Seven-Channel DMA Transfer Sequencer

This block sequences a system DMA unit that is built as two four-channel controllers joined in cascade. The channels are numbered 0 to 7. Channel 4 is the point where the two controllers meet, so it never moves data, which leaves seven usable channels. Channels 0 to 3 move one byte per transfer cycle. Channels 5 to 7 move one 16-bit word per cycle. Every address the block emits is 24 bits wide.

Software loads a channel through a single programming port. A load gives the channel a start address, a count that holds N-1 for N units, a direction, and the counting mode. The load also enables the channel. Devices then raise request lines. In each cycle the sequencer picks one eligible channel, by fixed or rotating priority, and grants it a single transfer cycle. For that cycle it drives a registered acknowledge, the memory address, the transfer width, a read or write strobe and a terminal-count flag. When the final unit moves, the channel disables itself until it is loaded again.

Top module: `dma_seq`

## Requirements
- R1: During reset and after it, every output is 0 and no channel is enabled, so requests give no grant until a channel is loaded.
- R2: Channel 4 is never granted, and a load aimed at channel 4 has no effect.
- R3: With rot_pri_i=0, the lowest-numbered eligible channel wins, so channel 0 has the highest priority.
- R4: With rot_pri_i=1, the search starts at the channel after the one granted most recently and wraps from 7 to 0. After reset the most recent grant counts as channel 7.
- R5: Channels 0 to 3 give word_o=0, and their address rises by 1 per transfer. In normal mode only prog_cnt_i[15:0] is used, so a loaded count C gives C+1 transfers.
- R6: Channels 5 to 7 give word_o=1, and address bit 0 is cleared at load. Their address rises by 2 per transfer, and in normal mode the count counts words.
- R7: With prog_ext_i=1, all 24 count bits are used. If prog_bcnt_i=1 is also set on a word channel, the count counts bytes and drops by 2 per transfer, so a count of 2M-1 gives M transfers.
- R8: tc_o is high together with the final transfer of a channel, that is, the transfer where the count would pass below zero. The channel then ignores requests until it is loaded again.
- R9: Addresses wrap modulo 2^24, so 0xFFFFFF is followed by 0x000000.
- R10: A request sampled at one rising edge shows up in the registered outputs at that same edge. dack_o is one-hot or zero, and xfer_o is 1 exactly when dack_o is nonzero.
- R11: During a transfer, mem_wr_o=1 if the channel was loaded with prog_wr_i=1, and mem_rd_o=1 otherwise. Both are 0 when no transfer takes place.
- R12: A channel that is being loaded in a cycle is not granted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Load strobe for the channel given by prog_ch_i |
| prog_ch_i | input | 3 | Channel number to load |
| prog_addr_i | input | 24 | Start byte address |
| prog_cnt_i | input | 24 | Count, N-1 |
| prog_wr_i | input | 1 | 1 = write to memory, 0 = read from memory |
| prog_ext_i | input | 1 | Extended mode: 24-bit count |
| prog_bcnt_i | input | 1 | Count in bytes on a word channel (extended mode only) |
| rot_pri_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| dreq_i | input | 8 | Request line for each channel |
| dack_o | output | 8 | One-hot grant for the current transfer cycle |
| xfer_o | output | 1 | A transfer takes place in this cycle |
| addr_o | output | 24 | Byte address of the transfer |
| word_o | output | 1 | 1 = 16-bit transfer, 0 = 8-bit transfer |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| tc_o | output | 1 | Terminal count, set on the final transfer |

## Verification
The assertions check on every cycle the properties that hold in any single cycle:
- dack_o is one-hot or zero, and the cascade channel is never granted.
- The two strobes never overlap, and terminal count comes only with a transfer.
- Word addresses stay aligned, and the address steps correctly.
- A channel is disabled after its final transfer.
- Under fixed priority no lower-numbered request is passed over.
- A channel being loaded is not granted in that cycle.

Only the bench scenarios can show the behaviour that spans many cycles:
- the exact transfer counts in normal, extended and byte-count modes;
- the order of grants under rotating priority;
- the address wrap at the top of the 24-bit space;
- that a channel stays silent after terminal count until it is reloaded.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  parameter int ADDR_W     = 24;
  parameter int CNT_W      = 24;
  parameter int BASE_CNT_W = 16;
  parameter int NUM_CH     = 8;
  parameter int CASCADE_CH = 4;
  parameter int WORD_BASE  = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
    logic              wr;
    logic              ext;
    logic              bcnt;
  } chan_load_t;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_seq_pkg::*;
#(
  parameter bit IS_WORD = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  chan_load_t        ld_cfg_i,
  input  logic              adv_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tc_o,
  output logic              wr_o
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = IS_WORD ? ADDR_W'(2) : ADDR_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             bcnt_q;
  logic [CNT_W-1:0] cnt_step;

  assign cnt_step = bcnt_q ? CNT_W'(2) : CNT_W'(1);
  assign tc_o     = cnt_q < cnt_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      addr_o   <= '0;
      cnt_q    <= '0;
      bcnt_q   <= 1'b0;
      wr_o     <= 1'b0;
    end else if (ld_i) begin
      active_o <= 1'b1;
      addr_o   <= IS_WORD ? {ld_cfg_i.addr[ADDR_W-1:1], 1'b0} : ld_cfg_i.addr;
      cnt_q    <= ld_cfg_i.ext ? ld_cfg_i.cnt
                               : {{(CNT_W-BASE_CNT_W){1'b0}}, ld_cfg_i.cnt[BASE_CNT_W-1:0]};
      bcnt_q   <= IS_WORD && ld_cfg_i.ext && ld_cfg_i.bcnt;
      wr_o     <= ld_cfg_i.wr;
    end else if (adv_i) begin
      addr_o <= addr_o + ADDR_STEP;
      cnt_q  <= cnt_q - cnt_step;
      if (tc_o) active_o <= 1'b0;
    end
  end

  p_tc_disables_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && tc_o && !ld_i) |=> !active_o);

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !ld_i) |=> addr_o == $past(addr_o) + ADDR_STEP);

  if (IS_WORD) begin : g_align
    p_word_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_o |-> !addr_o[0]);
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N    = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          rot_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [IW-1:0] last_q;

  always_comb begin
    int base_v;
    int j;
    gnt_o  = '0;
    idx_o  = '0;
    any_o  = 1'b0;
    base_v = rot_i ? (int'(last_q) + 1) % N : 0;
    for (int k = 0; k < N; k++) begin
      j = (base_v + k) % N;
      if (!any_o && req_i[j]) begin
        any_o = 1'b1;
        idx_o = IW'(j);
      end
    end
    if (any_o) gnt_o[idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IW'(N-1);
    else if (any_o) last_q <= idx_o;
  end

  p_gnt_subset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  p_fixed_pri_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rot_i && any_o) |-> (req_i & (gnt_o - N'(1))) == '0);

  p_gnt_any_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o == (req_i != '0));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int CASC = CASCADE_CH,
  parameter int WBAS = WORD_BASE,
  localparam int IW  = $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_we_i,
  input  logic [IW-1:0]     prog_ch_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [CNT_W-1:0]  prog_cnt_i,
  input  logic              prog_wr_i,
  input  logic              prog_ext_i,
  input  logic              prog_bcnt_i,
  input  logic              rot_pri_i,
  input  logic [NCH-1:0]    dreq_i,
  output logic [NCH-1:0]    dack_o,
  output logic              xfer_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              word_o,
  output logic              mem_wr_o,
  output logic              mem_rd_o,
  output logic              tc_o
);
  chan_load_t        ld_cfg;
  logic [NCH-1:0]    ld_sel;
  logic [NCH-1:0]    ch_active;
  logic [NCH-1:0]    ch_tc;
  logic [NCH-1:0]    ch_wr;
  logic [ADDR_W-1:0] ch_addr [NCH];
  logic [NCH-1:0]    eligible;
  logic [NCH-1:0]    gnt;
  logic [IW-1:0]     win_idx;
  logic              win_any;

  assign ld_cfg = '{addr: prog_addr_i, cnt: prog_cnt_i, wr: prog_wr_i,
                    ext: prog_ext_i, bcnt: prog_bcnt_i};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ld_sel[i]   = prog_we_i && (prog_ch_i == IW'(i));
    assign eligible[i] = dreq_i[i] && ch_active[i] && !ld_sel[i];
    if (i == CASC) begin : g_cascade
      assign ch_active[i] = 1'b0;
      assign ch_tc[i]     = 1'b0;
      assign ch_wr[i]     = 1'b0;
      assign ch_addr[i]   = '0;
    end else begin : g_live
      dma_chan #(.IS_WORD(i >= WBAS)) u_chan (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ld_i     (ld_sel[i]),
        .ld_cfg_i (ld_cfg),
        .adv_i    (gnt[i]),
        .active_o (ch_active[i]),
        .addr_o   (ch_addr[i]),
        .tc_o     (ch_tc[i]),
        .wr_o     (ch_wr[i])
      );
    end
  end

  dma_arb #(.N(NCH)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (eligible),
    .rot_i  (rot_pri_i),
    .gnt_o  (gnt),
    .idx_o  (win_idx),
    .any_o  (win_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dack_o   <= '0;
      xfer_o   <= 1'b0;
      addr_o   <= '0;
      word_o   <= 1'b0;
      mem_wr_o <= 1'b0;
      mem_rd_o <= 1'b0;
      tc_o     <= 1'b0;
    end else begin
      dack_o   <= gnt;
      xfer_o   <= win_any;
      addr_o   <= win_any ? ch_addr[win_idx] : '0;
      word_o   <= win_any && (int'(win_idx) >= WBAS);
      mem_wr_o <= win_any && ch_wr[win_idx];
      mem_rd_o <= win_any && !ch_wr[win_idx];
      tc_o     <= win_any && ch_tc[win_idx];
    end
  end

  p_dack_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o) && (xfer_o == (dack_o != '0)));

  p_no_cascade_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dack_o[CASC]);

  p_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_wr_o && mem_rd_o) && (xfer_o == (mem_wr_o || mem_rd_o)));

  p_tc_with_xfer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> xfer_o);

  p_word_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> (word_o == ((dack_o >> WBAS) != '0)));

  p_load_blocks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_we_i |=> (dack_o & (NCH'(1) << $past(prog_ch_i))) == '0);
endmodule

// File: tb/tb_dma_seq.sv
module tb_dma_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we_i = 1'b0;
  logic [2:0]  prog_ch_i = '0;
  logic [23:0] prog_addr_i = '0;
  logic [23:0] prog_cnt_i = '0;
  logic        prog_wr_i = 1'b0;
  logic        prog_ext_i = 1'b0;
  logic        prog_bcnt_i = 1'b0;
  logic        rot_pri_i = 1'b0;
  logic [7:0]  dreq_i = '0;
  logic [7:0]  dack_o;
  logic        xfer_o;
  logic [23:0] addr_o;
  logic        word_o;
  logic        mem_wr_o;
  logic        mem_rd_o;
  logic        tc_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0]  dack;
    logic [23:0] addr;
    logic        word;
    logic        wr;
    logic        tc;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk_i = ~clk_i;

  dma_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_we_i(prog_we_i), .prog_ch_i(prog_ch_i),
    .prog_addr_i(prog_addr_i), .prog_cnt_i(prog_cnt_i), .prog_wr_i(prog_wr_i),
    .prog_ext_i(prog_ext_i), .prog_bcnt_i(prog_bcnt_i), .rot_pri_i(rot_pri_i),
    .dreq_i(dreq_i), .dack_o(dack_o), .xfer_o(xfer_o), .addr_o(addr_o),
    .word_o(word_o), .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o), .tc_o(tc_o)
  );

  task automatic drive(input logic [7:0] req, input logic [7:0] dk, input logic [23:0] a,
                       input logic wd, input logic wr, input logic tc, input string tag);
    exp_t e;
    @(negedge clk_i);
    prog_we_i = 1'b0;
    dreq_i    = req;
    e = '{dack: dk, addr: a, word: wd, wr: wr, tc: tc, tag: tag};
    q.push_back(e);
  endtask

  task automatic prog(input logic [2:0] ch, input logic [23:0] a, input logic [23:0] c,
                      input logic wr, input logic ext, input logic bc,
                      input logic [7:0] req, input string tag);
    exp_t e;
    @(negedge clk_i);
    prog_we_i   = 1'b1;
    prog_ch_i   = ch;
    prog_addr_i = a;
    prog_cnt_i  = c;
    prog_wr_i   = wr;
    prog_ext_i  = ext;
    prog_bcnt_i = bc;
    dreq_i      = req;
    e = '{dack: 8'h00, addr: 24'h0, word: 1'b0, wr: 1'b0, tc: 1'b0, tag: tag};
    q.push_back(e);
  endtask

  // scoreboard monitor
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic ok;
      e  = q.pop_front();
      ok = (dack_o == e.dack) && (xfer_o == (e.dack != 0)) && (tc_o == e.tc);
      if (e.dack != 0)
        ok = ok && (addr_o == e.addr) && (word_o == e.word) &&
             (mem_wr_o == e.wr) && (mem_rd_o == !e.wr);
      else
        ok = ok && !mem_wr_o && !mem_rd_o;
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL %s: got dack=%h addr=%h word=%b wr=%b rd=%b tc=%b exp dack=%h addr=%h word=%b wr=%b tc=%b",
                 e.tag, dack_o, addr_o, word_o, mem_wr_o, mem_rd_o, tc_o,
                 e.dack, e.addr, e.word, e.wr, e.tc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    total++;
    if (dack_o !== 8'h00 || xfer_o !== 1'b0 || addr_o !== 24'h0 || word_o !== 1'b0 ||
        mem_wr_o !== 1'b0 || mem_rd_o !== 1'b0 || tc_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: got dack=%h xfer=%b tc=%b exp all zero", dack_o, xfer_o, tc_o);
    end
    rst_ni = 1'b1;

    // R1: nothing loaded, no grant
    drive(8'hFF, 8'h00, 24'h0, 0, 0, 0, "R1");
    drive(8'hFF, 8'h00, 24'h0, 0, 0, 0, "R1");

    // R5/R8/R10/R11: byte channel 1, three transfers, memory write
    prog(3'd1, 24'h000100, 24'd2, 1, 0, 0, 8'h00, "R5");
    drive(8'h02, 8'h02, 24'h000100, 0, 1, 0, "R10");
    drive(8'h02, 8'h02, 24'h000101, 0, 1, 0, "R5");
    drive(8'h02, 8'h02, 24'h000102, 0, 1, 1, "R8");
    drive(8'h02, 8'h00, 24'h0, 0, 0, 0, "R8");
    drive(8'h02, 8'h00, 24'h0, 0, 0, 0, "R8");

    // R6/R11: word channel 5, odd address aligned, memory read
    prog(3'd5, 24'h123457, 24'd1, 0, 0, 0, 8'h00, "R6");
    drive(8'h20, 8'h20, 24'h123456, 1, 0, 0, "R11");
    drive(8'h20, 8'h20, 24'h123458, 1, 0, 1, "R6");
    drive(8'h20, 8'h00, 24'h0, 0, 0, 0, "R6");

    // R2/R3: fixed priority; load to channel 4 ignored
    prog(3'd0, 24'h000010, 24'd5, 1, 0, 0, 8'h00, "R3");
    prog(3'd2, 24'h000020, 24'd5, 1, 0, 0, 8'h00, "R3");
    prog(3'd4, 24'h000080, 24'd5, 1, 0, 0, 8'h00, "R2");
    prog(3'd6, 24'h000040, 24'd5, 0, 0, 0, 8'h00, "R3");
    drive(8'h55, 8'h01, 24'h000010, 0, 1, 0, "R3");
    drive(8'h55, 8'h01, 24'h000011, 0, 1, 0, "R3");
    drive(8'h54, 8'h04, 24'h000020, 0, 1, 0, "R3");
    drive(8'h10, 8'h00, 24'h0, 0, 0, 0, "R2");

    // R4: rotating priority, last grant was channel 2
    @(negedge clk_i);
    rot_pri_i = 1'b1;
    dreq_i = 8'h00;
    q.push_back('{dack: 8'h00, addr: 24'h0, word: 1'b0, wr: 1'b0, tc: 1'b0, tag: "R4"});
    drive(8'h45, 8'h40, 24'h000040, 1, 0, 0, "R4");
    drive(8'h45, 8'h01, 24'h000012, 0, 1, 0, "R4");
    drive(8'h45, 8'h04, 24'h000021, 0, 1, 0, "R4");
    drive(8'h45, 8'h40, 24'h000042, 1, 0, 0, "R4");
    @(negedge clk_i);
    rot_pri_i = 1'b0;
    dreq_i = 8'h00;
    q.push_back('{dack: 8'h00, addr: 24'h0, word: 1'b0, wr: 1'b0, tc: 1'b0, tag: "R4"});

    // R7: extended byte count on word channel 7: count 5 -> 3 transfers
    prog(3'd7, 24'h200000, 24'd5, 1, 1, 1, 8'h00, "R7");
    drive(8'h80, 8'h80, 24'h200000, 1, 1, 0, "R7");
    drive(8'h80, 8'h80, 24'h200002, 1, 1, 0, "R7");
    drive(8'h80, 8'h80, 24'h200004, 1, 1, 1, "R7");
    drive(8'h80, 8'h00, 24'h0, 0, 0, 0, "R7");

    // R7 vs R5: count 0x010000 is large in extended mode, 0 would be tc otherwise
    prog(3'd3, 24'h000300, 24'h010000, 0, 1, 0, 8'h00, "R7");
    drive(8'h08, 8'h08, 24'h000300, 0, 0, 0, "R7");
    prog(3'd3, 24'h000300, 24'h010001, 0, 0, 0, 8'h00, "R5");
    drive(8'h08, 8'h08, 24'h000300, 0, 0, 0, "R5");
    drive(8'h08, 8'h08, 24'h000301, 0, 0, 1, "R5");
    drive(8'h08, 8'h00, 24'h0, 0, 0, 0, "R8");

    // R9: address wrap, reload after terminal count re-enables
    prog(3'd1, 24'hFFFFFF, 24'd1, 1, 0, 0, 8'h00, "R9");
    drive(8'h02, 8'h02, 24'hFFFFFF, 0, 1, 0, "R9");
    drive(8'h02, 8'h02, 24'h000000, 0, 1, 1, "R9");

    // R12: active channel 0 loaded while requesting
    prog(3'd0, 24'h000500, 24'd0, 1, 0, 0, 8'h01, "R12");
    drive(8'h01, 8'h01, 24'h000500, 0, 1, 1, "R12");
    drive(8'h00, 8'h00, 24'h0, 0, 0, 0, "R12");

    while (q.size() > 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule